// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device-side read path of a single-data-line serial memory. It watches an active-low chip select, a serial clock and a serial input line, all oversampled by a fast system clock. After chip select falls it collects an 8-bit command code and a 24-bit address on rising serial clock edges, most significant bit first. It recognises a plain read and a fast read, which adds a fixed number of dummy clocks. It then streams bytes from an internal array onto a serial output line, changing the line on falling serial clock edges.

The output has a separate enable, so the pad is high impedance everywhere except in the data phase. The read address advances after every byte and wraps to the bottom of the array, so one command can stream the whole array any number of times until chip select rises. A busy flag from a write or erase engine suppresses reads. A preload port fills the array, one byte per system clock.

Top module: `sflash_read_resp`

## Requirements
- R1: Command code 0x03 is a plain read. After the 8 code bits and 24 address bits have been captured on rising serial clock edges (MSB first), bit 7 of the byte at that address is driven on the very next falling edge.
- R2: Command code 0x0B is a fast read. Exactly DUMMY_CYC (default 8) further rising edges follow the address, and bit 7 of the first byte is driven on the falling edge after the last dummy rise.
- R3: Each data byte is sent MSB first, bit 7 down to bit 0. The output bit changes only on a falling serial clock edge.
- R4: The output enable is low while chip select is high and during the code, address and dummy phases. It is also low out of reset.
- R5: After the eighth bit of a byte, the read address advances by one. The next byte follows with no gap, from any start address.
- R6: The array is indexed by the low log2(DEPTH) address bits, and upper address bits are ignored. After the top location the stream continues at location 0 with no gap, and it continues for as long as chip select stays low.
- R7: Raising chip select ends a command at any point. The output enable drops on the next system clock, and the next command decodes from its first bit.
- R8: If busy_i is high when the last command code bit is captured, the read is not performed, and the output enable stays low until chip select rises.
- R9: Any other command code is ignored, and the output enable stays low until chip select rises.
- R10: When pre_we_i is high on a system clock edge, pre_data_i is stored at pre_addr_i, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial command and address input |
| busy_i | input | 1 | Write or erase engine is busy |
| pre_we_i | input | 1 | Preload write enable |
| pre_addr_i | input | log2(DEPTH) | Preload array address |
| pre_data_i | input | 8 | Preload data byte |
| so_o | output | 1 | Serial data out bit |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |

## Verification
The assertions assume that chip select, serial clock and serial input are already synchronous to clk_i. They also assume that each serial clock level lasts at least two system clocks, and that chip select only moves while the serial clock is low. The stimulus meets these conditions by changing at most one serial pin per falling system clock edge, using two system clocks per serial clock half period. Chip select toggles only after the serial clock has returned low. busy_i is held steady for the whole of a command.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 24;
  localparam logic [CMD_W-1:0] OPC_READ = 8'h03;
  localparam logic [CMD_W-1:0] OPC_FAST = 8'h0B;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGN
  } sfr_state_e;
endpackage

// File: rtl/sfr_edge_det.sv
module sfr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/sfr_mem.sv
module sfr_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sfr_decoder.sv
module sfr_decoder
  import sfr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DUMMY_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int CW = $clog2(ADDR_W);
  localparam logic [CW-1:0] OPC_LAST   = CW'(CMD_W - 1);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] DUMMY_LAST = CW'(DUMMY_CYC - 1);

  sfr_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic [CMD_W-1:0] sh_q;
  logic             fast_q;
  logic [AW-1:0]    addr_q;
  logic [7:0]       tx_q;
  logic [2:0]       bidx_q;
  logic             so_q, oe_q;
  logic [CMD_W-1:0] opc_next;

  assign opc_next = {sh_q[CMD_W-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OPC;
      cnt_q  <= '0;
      sh_q   <= '0;
      fast_q <= 1'b0;
      addr_q <= '0;
      tx_q   <= '0;
      bidx_q <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_ni) begin
      st_q   <= ST_OPC;
      cnt_q  <= '0;
      bidx_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_OPC: if (rise_i) begin
          sh_q  <= opc_next;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == OPC_LAST) begin
            cnt_q  <= '0;
            fast_q <= (opc_next == OPC_FAST);
            if (!busy_i && (opc_next == OPC_READ || opc_next == OPC_FAST)) st_q <= ST_ADDR;
            else st_q <= ST_IGN;
          end
        end
        ST_ADDR: if (rise_i) begin
          addr_q <= {addr_q[AW-2:0], si_i};  // keeps only the low AW bits
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == ADDR_LAST) begin
            cnt_q  <= '0;
            bidx_q <= '0;
            st_q   <= fast_q ? ST_DUMMY : ST_DATA;
          end
        end
        ST_DUMMY: if (rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DUMMY_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_DATA;
          end
        end
        ST_DATA: if (fall_i) begin
          oe_q   <= 1'b1;
          bidx_q <= bidx_q + 1'b1;
          if (bidx_q == 3'd0) begin
            so_q <= rdata_i[7];
            tx_q <= {rdata_i[6:0], 1'b0};
          end else begin
            so_q <= tx_q[7];
            tx_q <= {tx_q[6:0], 1'b0};
          end
          if (bidx_q == 3'd7) addr_q <= addr_q + 1'b1;
        end
        ST_IGN: ;
        default: st_q <= ST_OPC;
      endcase
    end
  end

  assign raddr_o = addr_q;
  assign so_o    = so_q;
  assign so_oe_o = oe_q;

  p_cs_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_o);
  p_oe_data_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> st_q == ST_DATA);
  p_busy_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && st_q == ST_OPC && rise_i && cnt_q == OPC_LAST && busy_i) |=> st_q == ST_IGN);
  p_dummy_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && st_q == ST_DUMMY && rise_i && cnt_q == DUMMY_LAST) |=> st_q == ST_DATA);
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && st_q == ST_DATA && fall_i && bidx_q == 3'd7) |=> addr_q == AW'($past(addr_q) + 1'b1));
  p_first_bit_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> $past(fall_i));
endmodule

// File: rtl/sflash_read_resp.sv
module sflash_read_resp #(
  parameter int DEPTH     = 256,
  parameter int DUMMY_CYC = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic          pre_we_i,
  input  logic [AW-1:0] pre_addr_i,
  input  logic [7:0]    pre_data_i,
  output logic          so_o,
  output logic          so_oe_o
);
  logic          rise, fall;
  logic [AW-1:0] raddr;
  logic [7:0]    rdata;

  sfr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  sfr_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (pre_we_i),
    .waddr_i (pre_addr_i),
    .wdata_i (pre_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  sfr_decoder #(.AW(AW), .DUMMY_CYC(DUMMY_CYC)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .si_i    (si_i),
    .busy_i  (busy_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .so_o    (so_o),
    .so_oe_o (so_oe_o)
  );
endmodule

// File: tb/sflash_read_resp_tb.sv
module sflash_read_resp_tb;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, si = 1'b0, busy = 1'b0;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic so, so_oe;

  logic [7:0] mem_m [DEPTH];
  logic exp_oe = 1'b0, exp_so = 1'b0;
  int n_vec = 0, n_bad = 0;
  string cur_req = "R4";

  always #10 clk = ~clk;

  sflash_read_resp #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .si_i(si),
    .busy_i(busy), .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic tick();
    @(negedge clk);
    n_vec++;
    if (so_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s/R4 so_oe_o=%b expected %b at %0t", cur_req, so_oe, exp_oe, $time);
    end else if (exp_oe && so !== exp_so) begin
      n_bad++;
      $display("FAIL %s/R3 so_o=%b expected %b at %0t", cur_req, so, exp_so, $time);
    end
  endtask

  // ncyc serial clock periods; data falls start at the last header period
  task automatic do_cmd(input logic [7:0] op, input logic [23:0] addr,
                        input int ncyc, input logic bsy);
    int hdr;
    bit run;
    int base;
    bit q[$];
    hdr  = (op == 8'h0B) ? 40 : 32;
    run  = !bsy && (op == 8'h03 || op == 8'h0B);
    base = int'(addr) % DEPTH;
    for (int k = 0; k < ncyc / 8 + 2; k++) begin
      logic [7:0] v;
      v = mem_m[(base + k) % DEPTH];
      for (int b = 7; b >= 0; b--) q.push_back(v[b]);
    end
    busy = bsy;
    tick(); cs_ni = 1'b0;
    tick();
    for (int i = 0; i < ncyc; i++) begin
      si = (i < 8) ? op[7-i] : (i < 32) ? addr[31-i] : 1'b0;
      tick(); sclk = 1'b1;
      tick();
      tick(); sclk = 1'b0;
      if (run && i >= hdr - 1) begin
        exp_oe = 1'b1;
        exp_so = q.pop_front();
      end
      tick();
    end
    cs_ni = 1'b1; exp_oe = 1'b0;
    tick();
    tick(); busy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R4: reset state
    cur_req = "R4";
    tick(); tick();
    rst_ni = 1'b1;
    tick();

    // preload through the backdoor port
    cur_req = "R10";
    for (int i = 0; i < DEPTH; i++) begin
      tick();
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = 8'((i * 37 + 11) & 8'hFF);
      mem_m[i] = 8'((i * 37 + 11) & 8'hFF);
    end
    tick(); pre_we = 1'b0;

    cur_req = "R1";
    do_cmd(8'h03, 24'h000010, 32 + 3 * 8 - 1, 1'b0);

    cur_req = "R10";
    tick(); pre_we = 1'b1; pre_addr = AW'(8'h10); pre_data = 8'h5A; mem_m[16] = 8'h5A;
    tick(); pre_we = 1'b0;
    do_cmd(8'h03, 24'h000010, 32 + 8 - 1, 1'b0);

    cur_req = "R2";
    do_cmd(8'h0B, 24'h0000A5, 40 + 2 * 8 - 1, 1'b0);

    cur_req = "R5";
    do_cmd(8'h03, 24'h00007F, 32 + 4 * 8 - 1, 1'b0);

    cur_req = "R6";
    do_cmd(8'h0B, 24'hAB00FE, 40 + 4 * 8 - 1, 1'b0);
    do_cmd(8'h03, 24'h000003, 32 + (DEPTH + 2) * 8 - 1, 1'b0);

    cur_req = "R7";
    do_cmd(8'h03, 24'h000040, 20, 1'b0);
    do_cmd(8'h03, 24'h000005, 32 + 2 * 8 - 1, 1'b0);
    do_cmd(8'h0B, 24'h000033, 43, 1'b0);
    do_cmd(8'h03, 24'h000021, 32 + 12, 1'b0);
    do_cmd(8'h0B, 24'h0000C0, 40 + 8 - 1, 1'b0);

    cur_req = "R8";
    do_cmd(8'h03, 24'h000010, 60, 1'b1);
    do_cmd(8'h0B, 24'h000020, 60, 1'b1);
    do_cmd(8'h03, 24'h000011, 32 + 8 - 1, 1'b0);

    cur_req = "R9";
    do_cmd(8'h9F, 24'h000000, 60, 1'b0);
    do_cmd(8'h02, 24'h000001, 45, 1'b0);
    do_cmd(8'h0B, 24'h0000FF, 40 + 2 * 8 - 1, 1'b0);

    repeat (4) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule